// File: doc/BRIEF.md
# Relocatable Local Memory Map Decoder

This block turns a 20-bit processor byte address into byte-lane chip selects for the on-board memories. It covers five regions:

- a program memory bank that always ends at the top of the address space;
- a RAM bank that can sit either at address zero or directly under the program bank;
- a 16 KB on-chip peripheral memory;
- an optional RAM expansion board;
- an off-board local bus window.

Static configuration inputs choose the sizes and the placement. When the RAM bank moves to the top, the peripheral memory follows it, staying just beneath it. The off-board window then starts at zero.

Every region is sixteen bits wide and is split into an even lane and an odd lane. Each lane has its own select. The selects are registered, so a decoded address appears on the outputs one clock after it is presented. A memory-protect input suppresses every select, which guards stored data during power transitions.

Top module: `mmap_decoder`

## Requirements
- R1: With program size code `prom_size` of 0, 1, 2 or 3, the program bank select covers F8000h, F0000h, E0000h or C0000h respectively, up to FFFFFh.
- R2: With the RAM bank at the bottom (RAM code 000, 001, 010 or 011), the peripheral memory covers the 16 KB directly below the program bank base. For size codes 0 to 3 this is F4000h, EC000h, DC000h or BC000h.
- R3: RAM codes 000, 001 and 010 decode the RAM bank at 0–01FFFh, 0–07FFFh and 0–1FFFFh respectively. Code 011 selects no RAM.
- R4: RAM codes 100, 101 and 110 decode the RAM bank directly below the program bank, with a span of 32 KB, 64 KB or 128 KB. This gives F0000h–F7FFFh, E0000h–EFFFFh and C0000h–DFFFFh when the program bank is set to the matching size. The peripheral memory then sits in the 16 KB directly below the RAM bank.
- R5: RAM code 111 selects neither the RAM bank nor the peripheral memory anywhere in the map.
- R6: With `exp_en` high and RAM codes 000, 001 or 010, the expansion board occupies the span directly above the RAM bank, equal in size to it. This gives 02000h–03FFFh, 08000h–0FFFFh and 20000h–3FFFFh. In top placement the expansion select never asserts.
- R7: The off-board bus window covers every address from its base upward that no on-board region claims. The base is the first address above the RAM bank, or above the expansion span when it is enabled. The base is 00000h in top placement, for code 011 and for code 111.
- R8: The peripheral memory select asserts only when `pmem_en` is high. When it is low, those addresses fall to the off-board window.
- R9: While `protect` is high, no select output asserts.
- R10: Each select is 2 bits. Bit 0 is the even lane and asserts when A0 is 0. Bit 1 is the odd lane and asserts when `bhe_n` is 0. An access with A0=1 and `bhe_n`=1 asserts nothing.
- R11: At most one region is selected per cycle. On-board regions take priority over the off-board window.
- R12: Selects are registered with one cycle of latency and are all zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Processor byte address |
| bhe_n | input | 1 | Active-low high-byte enable |
| prom_size | input | 2 | Program bank device size code |
| ram_code | input | 3 | RAM bank size and placement code |
| pmem_en | input | 1 | Peripheral memory enable |
| exp_en | input | 1 | Expansion board enable |
| protect | input | 1 | Memory protect, blocks all selects |
| prom_cs | output | 2 | Program bank lane selects {odd, even} |
| ram_cs | output | 2 | RAM bank lane selects {odd, even} |
| pmem_cs | output | 2 | Peripheral memory lane selects {odd, even} |
| exp_cs | output | 2 | Expansion board lane selects {odd, even} |
| bus_cs | output | 2 | Off-board window lane selects {odd, even} |

## Verification
The assertions watch four properties on every cycle:
- protect blanks all selects;
- a disabled peripheral memory stays silent;
- expansion is never selected in top placement;
- no select appears for an access that enables neither lane, and no two regions are ever selected together.

Only the bench scenarios can show where each region begins and ends for each size and placement code. They probe addresses on both sides of every boundary, the window shifting when the RAM bank relocates, and the fall-through of disabled regions to the off-board window.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int NREG    = 5;
  localparam int RG_PROM = 0;
  localparam int RG_RAM  = 1;
  localparam int RG_PMEM = 2;
  localparam int RG_EXP  = 3;
  localparam int RG_BUS  = 4;
  localparam int NLANE   = 2;
endpackage

// File: rtl/mmap_bounds.sv
module mmap_bounds
  import mmap_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PROM_UNIT  = 32768,
  parameter int RAM_UNIT   = 8192,
  parameter int PMEM_BYTES = 16384
) (
  input  logic [1:0]      prom_size,
  input  logic [2:0]      ram_code,
  input  logic            pmem_en,
  input  logic            exp_en,
  output logic [ADDR_W:0] win_lo [NREG],
  output logic [ADDR_W:0] win_hi [NREG],
  output logic            win_en [NREG]
);
  localparam int          BW     = ADDR_W + 1;
  localparam logic [BW-1:0] TOP  = BW'(1) << ADDR_W;
  localparam logic [BW-1:0] PUNIT = BW'(PROM_UNIT);
  localparam logic [BW-1:0] RUNIT = BW'(RAM_UNIT);
  localparam logic [BW-1:0] PMEM  = BW'(PMEM_BYTES);

  logic [BW-1:0] prom_lo, bot_span, top_span, ram_lo, ram_hi, exp_hi;
  logic          bottom, topmode, disabled;

  always_comb begin
    prom_lo  = TOP - (PUNIT << prom_size);
    disabled = (ram_code == 3'b111);
    bottom   = !ram_code[2] && (ram_code[1:0] != 2'b11);
    topmode  = ram_code[2] && !disabled;
    bot_span = RUNIT << {ram_code[1:0], 1'b0};
    top_span = PUNIT << ram_code[1:0];
    ram_lo   = topmode ? (prom_lo - top_span) : '0;
    ram_hi   = topmode ? prom_lo : bot_span;
    exp_hi   = bot_span << 1;

    win_lo[RG_PROM] = prom_lo;
    win_hi[RG_PROM] = TOP;
    win_en[RG_PROM] = 1'b1;

    win_lo[RG_RAM]  = ram_lo;
    win_hi[RG_RAM]  = ram_hi;
    win_en[RG_RAM]  = bottom || topmode;

    win_lo[RG_PMEM] = (topmode ? ram_lo : prom_lo) - PMEM;
    win_hi[RG_PMEM] = topmode ? ram_lo : prom_lo;
    win_en[RG_PMEM] = pmem_en && !disabled;

    win_lo[RG_EXP]  = bot_span;
    win_hi[RG_EXP]  = exp_hi;
    win_en[RG_EXP]  = bottom && exp_en;

    win_lo[RG_BUS]  = !bottom ? '0 : (exp_en ? exp_hi : bot_span);
    win_hi[RG_BUS]  = TOP;
    win_en[RG_BUS]  = 1'b1;
  end
endmodule

// File: rtl/mmap_window_match.sv
module mmap_window_match #(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W:0]   lo,
  input  logic [ADDR_W:0]   hi,
  input  logic              en,
  output logic              hit
);
  logic [ADDR_W:0] ext;
  always_comb begin
    ext = {1'b0, addr};
    hit = en && (ext >= lo) && (ext < hi);
  end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PROM_UNIT  = 32768,
  parameter int RAM_UNIT   = 8192,
  parameter int PMEM_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bhe_n,
  input  logic [1:0]        prom_size,
  input  logic [2:0]        ram_code,
  input  logic              pmem_en,
  input  logic              exp_en,
  input  logic              protect,
  output logic [NLANE-1:0]  prom_cs,
  output logic [NLANE-1:0]  ram_cs,
  output logic [NLANE-1:0]  pmem_cs,
  output logic [NLANE-1:0]  exp_cs,
  output logic [NLANE-1:0]  bus_cs
);
  logic [ADDR_W:0]  win_lo [NREG];
  logic [ADDR_W:0]  win_hi [NREG];
  logic             win_en [NREG];
  logic [NREG-1:0]  raw_hit;
  logic [NREG-1:0]  sel;
  logic [NLANE-1:0] lanes;
  logic [NLANE-1:0] cs_nxt [NREG];
  logic [NLANE-1:0] cs_q   [NREG];

  mmap_bounds #(
    .ADDR_W(ADDR_W), .PROM_UNIT(PROM_UNIT),
    .RAM_UNIT(RAM_UNIT), .PMEM_BYTES(PMEM_BYTES)
  ) u_bounds (
    .prom_size(prom_size), .ram_code(ram_code),
    .pmem_en(pmem_en), .exp_en(exp_en),
    .win_lo(win_lo), .win_hi(win_hi), .win_en(win_en)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_match
    mmap_window_match #(.ADDR_W(ADDR_W)) u_match (
      .addr(addr), .lo(win_lo[g]), .hi(win_hi[g]),
      .en(win_en[g]), .hit(raw_hit[g])
    );
  end

  // Next-state: priority of on-board regions over the window, lane split
  always_comb begin
    sel          = raw_hit;
    sel[RG_BUS]  = raw_hit[RG_BUS] && !(|raw_hit[RG_BUS-1:0]);
    lanes        = {!bhe_n, !addr[0]};
    for (int i = 0; i < NREG; i++) begin
      cs_nxt[i] = (sel[i] && !protect) ? lanes : '0;
    end
  end

  // Register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) cs_q[i] <= cs_nxt[i];
    end
  end

  assign prom_cs = cs_q[RG_PROM];
  assign ram_cs  = cs_q[RG_RAM];
  assign pmem_cs = cs_q[RG_PMEM];
  assign exp_cs  = cs_q[RG_EXP];
  assign bus_cs  = cs_q[RG_BUS];

  // R9
  protect_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    protect |=> (prom_cs == '0 && ram_cs == '0 && pmem_cs == '0 &&
                 exp_cs == '0 && bus_cs == '0));

  // R8
  pmem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pmem_en |=> (pmem_cs == '0));

  // R6
  exp_top_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_code[2] |=> (exp_cs == '0));

  // R10
  no_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[0] && bhe_n) |=> (prom_cs == '0 && ram_cs == '0 && pmem_cs == '0 &&
                            exp_cs == '0 && bus_cs == '0));

  // R11
  one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|prom_cs, |ram_cs, |pmem_cs, |exp_cs, |bus_cs}));
endmodule

// File: tb/mmap_decoder_bench.sv
module mmap_decoder_bench;
  localparam int CLK_P = 10;

  typedef struct {
    logic [9:0] exp;
    string      tag;
    logic [19:0] a;
  } item_t;

  logic        clk, rst_n, bhe_n, pmem_en, exp_en, protect;
  logic [19:0] addr;
  logic [1:0]  prom_size;
  logic [2:0]  ram_code;
  logic [1:0]  prom_cs, ram_cs, pmem_cs, exp_cs, bus_cs;

  int    n_run, n_fail;
  item_t sb [$];

  mmap_decoder u_mmap_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .bhe_n(bhe_n),
    .prom_size(prom_size), .ram_code(ram_code), .pmem_en(pmem_en),
    .exp_en(exp_en), .protect(protect), .prom_cs(prom_cs), .ram_cs(ram_cs),
    .pmem_cs(pmem_cs), .exp_cs(exp_cs), .bus_cs(bus_cs)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Reference model from the requirements; vector {bus,exp,pmem,ram,prom}
  function automatic logic [9:0] model(logic [1:0] sz, logic [2:0] rc,
      logic pen, logic een, logic prot, logic [19:0] a, logic bhe);
    logic [19:0] plo, pm_lo, rlo, rhi, ehi, base;
    int rg;
    logic [9:0] v;
    case (sz)
      2'd0: begin plo = 20'hF8000; pm_lo = 20'hF4000; end
      2'd1: begin plo = 20'hF0000; pm_lo = 20'hEC000; end
      2'd2: begin plo = 20'hE0000; pm_lo = 20'hDC000; end
      default: begin plo = 20'hC0000; pm_lo = 20'hBC000; end
    endcase
    rlo = 20'h0; rhi = 20'h0; ehi = 20'h0;
    case (rc)
      3'd0: begin rhi = 20'h02000; ehi = 20'h04000; end
      3'd1: begin rhi = 20'h08000; ehi = 20'h10000; end
      3'd2: begin rhi = 20'h20000; ehi = 20'h40000; end
      3'd4: begin rlo = 20'hF0000; rhi = 20'hF8000; pm_lo = 20'hEC000; end
      3'd5: begin rlo = 20'hE0000; rhi = 20'hF0000; pm_lo = 20'hDC000; end
      3'd6: begin rlo = 20'hC0000; rhi = 20'hE0000; pm_lo = 20'hBC000; end
      default: ;
    endcase
    base = (rc < 3) ? (een ? ehi : rhi) : 20'h0;
    rg = 4;
    if (a >= plo) rg = 0;
    else if (rc != 3 && rc != 7 && a >= rlo && a < rhi) rg = 1;
    else if (pen && rc != 7 && a >= pm_lo && a < pm_lo + 20'h4000) rg = 2;
    else if (rc < 3 && een && a >= rhi && a < ehi) rg = 3;
    else if (a < base) rg = -1;
    v = '0;
    if (!prot && rg >= 0) begin
      v[rg*2]   = !a[0];
      v[rg*2+1] = !bhe;
    end
    return v;
  endfunction

  task automatic apply(logic [1:0] sz, logic [2:0] rc, logic pen, logic een,
                       logic prot, logic [19:0] a, logic bhe, string tag);
    item_t it;
    @(negedge clk);
    prom_size = sz; ram_code = rc; pmem_en = pen; exp_en = een;
    protect = prot; addr = a; bhe_n = bhe;
    it.exp = model(sz, rc, pen, een, prot, a, bhe);
    it.tag = tag;
    it.a   = a;
    sb.push_back(it);
  endtask

  // Monitor: one-cycle latency, sampled a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (sb.size() > 0) begin
      item_t it;
      logic [9:0] got;
      it  = sb.pop_front();
      got = {bus_cs, exp_cs, pmem_cs, ram_cs, prom_cs};
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%05h actual=%b expected=%b", it.tag, it.a, got, it.exp);
      end
    end
  end

  initial begin
    #(CLK_P*20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; addr = '0; bhe_n = 1'b0; prom_size = '0; ram_code = '0;
    pmem_en = 1'b1; exp_en = 1'b0; protect = 1'b0;
    repeat (3) @(negedge clk);
    n_run++;  // R12 reset state
    if ({bus_cs, exp_cs, pmem_cs, ram_cs, prom_cs} !== '0) begin
      n_fail++;
      $display("FAIL R12 reset actual=%b expected=0",
               {bus_cs, exp_cs, pmem_cs, ram_cs, prom_cs});
    end
    rst_n = 1'b1;

    // R1 program bank sizes and boundaries
    apply(0, 0, 1, 0, 0, 20'hFFFFE, 0, "R1");
    apply(0, 0, 1, 0, 0, 20'hF8000, 1, "R1");
    apply(3, 0, 1, 0, 0, 20'hC0000, 0, "R1");
    apply(1, 0, 1, 0, 0, 20'hF0000, 0, "R1");
    // R2 peripheral memory at bottom placement
    apply(0, 0, 1, 0, 0, 20'hF7FFF, 0, "R2");
    apply(0, 0, 1, 0, 0, 20'hF4000, 0, "R2");
    apply(3, 0, 1, 0, 0, 20'hBC000, 0, "R2");
    apply(0, 0, 1, 0, 0, 20'hF3FFE, 0, "R7");
    apply(3, 0, 1, 0, 0, 20'hBBFFE, 0, "R7");
    // R3 bottom RAM sizes
    apply(0, 0, 1, 0, 0, 20'h01FFE, 0, "R3");
    apply(0, 0, 1, 0, 0, 20'h02000, 0, "R7");
    apply(0, 1, 1, 0, 0, 20'h07FFE, 0, "R3");
    apply(0, 2, 1, 0, 0, 20'h1FFFE, 0, "R3");
    apply(0, 2, 1, 0, 0, 20'h20000, 0, "R7");
    apply(0, 3, 1, 0, 0, 20'h00000, 0, "R3");
    apply(0, 3, 1, 0, 0, 20'hF4000, 0, "R2");
    // R6 expansion
    apply(0, 0, 1, 1, 0, 20'h02000, 0, "R6");
    apply(0, 1, 1, 1, 0, 20'h08000, 0, "R6");
    apply(0, 1, 1, 1, 0, 20'h10000, 0, "R7");
    apply(0, 2, 1, 1, 0, 20'h3FFFE, 0, "R6");
    apply(0, 2, 1, 1, 0, 20'h40000, 0, "R7");
    // R4 top placement
    apply(0, 4, 1, 0, 0, 20'hF0000, 0, "R4");
    apply(0, 4, 1, 0, 0, 20'hF7FFE, 0, "R4");
    apply(0, 4, 1, 0, 0, 20'hEC000, 0, "R4");
    apply(0, 4, 1, 0, 0, 20'hEBFFE, 0, "R7");
    apply(0, 4, 1, 0, 0, 20'h00000, 0, "R7");
    apply(1, 5, 1, 1, 0, 20'hE0000, 0, "R4");
    apply(1, 5, 1, 1, 0, 20'hDC000, 0, "R4");
    apply(1, 5, 1, 1, 0, 20'h02000, 0, "R6");
    apply(3, 6, 1, 0, 0, 20'hDFFFE, 0, "R4");
    // R5 disabled RAM and peripheral memory
    apply(0, 7, 1, 0, 0, 20'h00000, 0, "R5");
    apply(0, 7, 1, 0, 0, 20'hF4000, 0, "R5");
    // R8 peripheral enable
    apply(0, 0, 0, 0, 0, 20'hF4000, 0, "R8");
    // R9 protect
    apply(0, 0, 1, 0, 1, 20'hFFFFE, 0, "R9");
    apply(0, 0, 1, 0, 1, 20'h00000, 0, "R9");
    // R10 lanes
    apply(0, 0, 1, 0, 0, 20'h00001, 0, "R10");
    apply(0, 0, 1, 0, 0, 20'h00001, 1, "R10");
    apply(0, 0, 1, 0, 0, 20'h01000, 1, "R10");
    // R11 priority over window
    apply(2, 0, 1, 1, 0, 20'hDC002, 0, "R11");
    apply(0, 0, 1, 0, 0, 20'h00000, 0, "R12");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule